// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block sequences one DMA channel through a chain of transfer descriptors held in memory. Each descriptor occupies a 32-byte aligned slot: word 0 is the next-link word, words 1 to 3 are reserved, and words 4 to 7 (byte offsets 0x10, 0x14, 0x18, 0x1C) carry the byte count, the source address, the destination address and the channel configuration. When started, the fetcher reads the useful words one at a time over a single-word read port, places them in working registers presented to the data mover, and loads the configuration word last so that its enable bit (bit 0) is what starts the segment.

When the data mover reports that the segment has finished, the fetcher clears the enable bit and inspects the link word. Bit 1 of the link means "chain enabled" and the bits from 5 upward give the address of the next descriptor; a link with that bit set and a non-zero address is followed, anything else (in particular a link of zero) ends the chain with a one-cycle completion pulse. A read error, or a descriptor whose count exceeds the per-descriptor limit of 0x1FFC bytes, aborts the chain with a one-cycle error pulse. The configuration word is passed through unchanged; the data mover decodes its fields (bits 3:2 direction, 1 meaning memory-to-peripheral and 2 peripheral-to-memory; bit 31 source increment; bit 30 destination increment; bits 14:12 and 18:16 log2 byte width of source and destination; bits 23:20 and 27:24 burst length minus one; request line number from bit 4).

Top module: `llf_chain_fetcher`

## Requirements
- R1: Synchronous active-low reset clears `busy`, `rd_req`, `seg_enable`, `chain_done`, `chain_err` and all working registers to zero.
- R2: A `start` pulse while idle begins a chain at `start_addr` with its low 5 bits forced to zero; `busy` and the first read request appear in the next cycle. A `start` while busy has no effect.
- R3: A descriptor is read at byte offsets 0x00, 0x10, 0x14, 0x18, 0x1C in that order, never at 0x04 to 0x0C; each request holds `rd_req` and a stable `rd_addr` until `rd_valid` is returned, and the next request follows in the cycle after acceptance.
- R4: Each accepted read word appears on its working register output (`seg_link`, `seg_count`, `seg_src`, `seg_dst`, `seg_cfg`) in the cycle after `rd_valid`.
- R5: `seg_done` has no effect while `seg_enable` is low; a descriptor whose configuration bit 0 is clear leaves the channel busy and paused.
- R6: On an accepted `seg_done`, a link word with bit 1 set and a non-zero value in bits 31:5 makes the next read request, one cycle later, at that address with the low 5 bits zero.
- R7: On an accepted `seg_done`, a link word with bit 1 clear or bits 31:5 zero ends the chain: `chain_done` is high for exactly one cycle, the cycle after `seg_done`, and `busy` drops in that same cycle.
- R8: A read returned with `rd_err` aborts the chain: `chain_err` is high for exactly one cycle, the cycle after the response, `busy` drops then and no further reads are made.
- R9: A count word above 0x1FFC aborts the chain exactly as in R8; a count of exactly 0x1FFC is accepted.
- R10: `seg_enable` equals bit 0 of the loaded configuration word, is low while descriptors are being read, and clears in the cycle after an accepted `seg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a chain (honoured only when idle) |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Chain in progress |
| rd_req | output | 1 | Single-word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read response; accepts the request |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response carries an error |
| seg_link | output | 32 | Loaded link word |
| seg_count | output | 32 | Loaded byte count |
| seg_src | output | 32 | Loaded source address |
| seg_dst | output | 32 | Loaded destination address |
| seg_cfg | output | 32 | Loaded configuration word (bit 0 cleared by the block) |
| seg_enable | output | 1 | Segment enable to the data mover |
| seg_done | input | 1 | Data mover reports the segment finished |
| chain_done | output | 1 | One-cycle chain completion pulse |
| chain_err | output | 1 | One-cycle chain abort pulse |

## Verification
The assertions watch, on every cycle, the read handshake (request held with a stable address, only the five legal word offsets, count read directly after the link), the enable never being high during a fetch, the enable clearing after an accepted segment end, and the shape and timing of the completion and error pulses. Which descriptor gets fetched next, whether a chain ends or follows its link, the ignoring of a busy start, the count limit, and the stall of a disabled descriptor depend on memory contents and are shown only by the bench's chains, which drive a reference model cycle by cycle alongside the design under randomly stalled read responses.

// File: rtl/llf_pkg.sv
// Shared definitions for the linked-list descriptor fetcher.
// Assumes the fixed 32-byte descriptor layout: link at word 0, three
// reserved words, then count, source, destination, configuration.
package llf_pkg;

    localparam int DESC_BYTES = 32;
    localparam int ALIGN_W    = $clog2(DESC_BYTES);
    localparam int WOFF_W     = ALIGN_W - 2;
    localparam int STEPS      = 5;

    localparam logic [2:0] STEP_LINK = 3'd0;
    localparam logic [2:0] STEP_CNT  = 3'd1;
    localparam logic [2:0] STEP_SRC  = 3'd2;
    localparam logic [2:0] STEP_DST  = 3'd3;
    localparam logic [2:0] STEP_CFG  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN
    } llf_state_t;

    // Word index inside the descriptor for a fetch step (reserved words skipped).
    function automatic logic [WOFF_W-1:0] step_word(input logic [2:0] step);
        return (step == STEP_LINK) ? WOFF_W'(0) : WOFF_W'(step + 3'd3);
    endfunction

endpackage

// File: rtl/llf_link_decode.sv
// Decodes the link word of the loaded descriptor.
// Assumes the chain flag sits in bit 1 and the next descriptor address in
// the bits from ALIGN_W upward; a zero address never counts as a link.
module llf_link_decode
    import llf_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  chain_bit,
    input  logic [WORD_W-1:ALIGN_W] link_hi,
    output logic                  follow,
    output logic [WORD_W-1:0]     next_addr
);

    // Follow only when the flag is set and the address part is non-zero.
    always_comb begin
        follow    = chain_bit && (|link_hi);
        next_addr = {link_hi, {ALIGN_W{1'b0}}};
    end

endmodule

// File: rtl/llf_desc_regs.sv
// Working registers of the channel, one per fetched descriptor word.
// Assumes only one word is loaded per cycle; the configuration register
// alone can have its enable bit (bit 0) cleared by the sequencer.
module llf_desc_regs
    import llf_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2:0]        load_step,
    input  logic [WORD_W-1:0] load_data,
    input  logic              clr_en,
    output logic [WORD_W-1:0] words [STEPS]
);

    for (genvar i = 0; i < STEPS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;

        if (i == int'(STEP_CFG)) begin : g_cfg
            // Configuration word: loaded last, enable bit cleared on request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (load && load_step == 3'(i)) begin
                    word_q <= load_data;
                end else if (clr_en) begin
                    word_q[0] <= 1'b0;
                end
            end
        end else begin : g_plain
            // Plain descriptor word: captured when its step is accepted.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (load && load_step == 3'(i)) begin
                    word_q <= load_data;
                end
            end
        end

        assign words[i] = word_q;
    end

endmodule

// File: rtl/llf_fetch_seq.sv
// Fetch sequencer: walks the useful words of each descriptor with one
// outstanding read, waits for the segment to finish, then follows the link
// or ends the chain. Assumes the base address is descriptor aligned and
// that the responder may stall rd_valid for any number of cycles.
module llf_fetch_seq
    import llf_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_BYTES = 'h1FFC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [WORD_W-1:ALIGN_W] start_hi,
    input  logic                    rd_valid,
    input  logic                    rd_err,
    input  logic [WORD_W-1:0]       rd_data,
    input  logic                    seg_enable,
    input  logic                    seg_done,
    input  logic                    follow,
    input  logic [WORD_W-1:0]       next_addr,
    output logic                    busy,
    output logic                    rd_req,
    output logic [WORD_W-1:0]       rd_addr,
    output logic                    load,
    output logic [2:0]              load_step,
    output logic                    clr_en,
    output logic                    chain_done,
    output logic                    chain_err
);

    localparam logic [WORD_W-1:0] MAX_W = WORD_W'(MAX_BYTES);

    llf_state_t        state_q;
    logic [2:0]        step_q;
    logic [WORD_W-1:0] base_q;
    logic              accept;
    logic              bad_cnt;
    logic              seg_ok;
    logic              start_ok;

    // Handshake and decision terms of the current cycle.
    always_comb begin
        accept    = (state_q == ST_FETCH) && rd_valid;
        bad_cnt   = (step_q == STEP_CNT) && (rd_data > MAX_W);
        seg_ok    = (state_q == ST_RUN) && seg_done && seg_enable;
        start_ok  = (state_q == ST_IDLE) && start;
        load      = accept && !rd_err;
        load_step = step_q;
        clr_en    = start_ok || seg_ok;
        busy      = (state_q != ST_IDLE);
        rd_req    = (state_q == ST_FETCH);
        rd_addr   = base_q | {{(WORD_W-ALIGN_W){1'b0}}, step_word(step_q), 2'b00};
    end

    // Chain state machine with registered completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= STEP_LINK;
            base_q     <= '0;
            chain_done <= 1'b0;
            chain_err  <= 1'b0;
        end else begin
            chain_done <= 1'b0;
            chain_err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= {start_hi, {ALIGN_W{1'b0}}};
                        step_q  <= STEP_LINK;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (accept) begin
                        if (rd_err || bad_cnt) begin
                            chain_err <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else if (step_q == STEP_CFG) begin
                            state_q <= ST_RUN;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                ST_RUN: begin
                    if (seg_ok) begin
                        if (follow) begin
                            base_q  <= next_addr;
                            step_q  <= STEP_LINK;
                            state_q <= ST_FETCH;
                        end else begin
                            chain_done <= 1'b1;
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/llf_chain_fetcher.sv
// Top of the per-channel linked-list descriptor fetcher.
// Assumes one channel, single-word reads with one request outstanding, and
// a data mover that acts only while seg_enable is high.
module llf_chain_fetcher
    import llf_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_BYTES = 'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    output logic              busy,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_err,
    output logic [WORD_W-1:0] seg_link,
    output logic [WORD_W-1:0] seg_count,
    output logic [WORD_W-1:0] seg_src,
    output logic [WORD_W-1:0] seg_dst,
    output logic [WORD_W-1:0] seg_cfg,
    output logic              seg_enable,
    input  logic              seg_done,
    output logic              chain_done,
    output logic              chain_err
);

    logic [WORD_W-1:0] words [STEPS];
    logic              load;
    logic [2:0]        load_step;
    logic              clr_en;
    logic              follow;
    logic [WORD_W-1:0] next_addr;

    // Present the working registers to the data mover.
    always_comb begin
        seg_link   = words[STEP_LINK];
        seg_count  = words[STEP_CNT];
        seg_src    = words[STEP_SRC];
        seg_dst    = words[STEP_DST];
        seg_cfg    = words[STEP_CFG];
        seg_enable = words[STEP_CFG][0];
    end

    llf_fetch_seq #(
        .WORD_W    (WORD_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_hi   (start_addr[WORD_W-1:ALIGN_W]),
        .rd_valid   (rd_valid),
        .rd_err     (rd_err),
        .rd_data    (rd_data),
        .seg_enable (seg_enable),
        .seg_done   (seg_done),
        .follow     (follow),
        .next_addr  (next_addr),
        .busy       (busy),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .load       (load),
        .load_step  (load_step),
        .clr_en     (clr_en),
        .chain_done (chain_done),
        .chain_err  (chain_err)
    );

    llf_desc_regs #(
        .WORD_W (WORD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_step (load_step),
        .load_data (rd_data),
        .clr_en    (clr_en),
        .words     (words)
    );

    llf_link_decode #(
        .WORD_W (WORD_W)
    ) u_link (
        .chain_bit (words[STEP_LINK][1]),
        .link_hi   (words[STEP_LINK][WORD_W-1:ALIGN_W]),
        .follow    (follow),
        .next_addr (next_addr)
    );

endmodule

// File: rtl/llf_chain_fetcher_chk.sv
// Protocol checker for the descriptor fetcher, attached by bind.
// Assumes the port names of llf_chain_fetcher; observes only.
module llf_chain_fetcher_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rd_req,
    input logic [WORD_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              rd_err,
    input logic              seg_enable,
    input logic              seg_done,
    input logic              chain_done,
    input logic              chain_err
);

    // R2: an idle start produces a request in the next cycle.
    a_r2_start_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && rd_req));

    // R3: a pending request keeps its address until answered.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R3: only the link and the four payload words are ever read.
    a_r3_legal_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[4:0] inside {5'h00, 5'h10, 5'h14, 5'h18, 5'h1C}));

    // R3: the count word follows the link word directly.
    a_r3_link_then_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && !rd_err && rd_addr[4:0] == 5'h00)
        |=> (rd_req && rd_addr[4:0] == 5'h10));

    // R10: the data mover is never enabled while words are being read.
    a_r10_no_en_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !seg_enable);

    // R10: an accepted segment end drops the enable.
    a_r10_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_enable && seg_done) |=> !seg_enable);

    // R7: completion lasts one cycle and leaves the channel idle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> (!busy && !chain_err) ##1 !chain_done);

    // R8: a read error aborts in the next cycle with no further requests.
    a_r8_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && rd_err) |=> (chain_err && !busy && !rd_req));

    // R8: the error pulse lasts one cycle.
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |=> !chain_err);

endmodule

bind llf_chain_fetcher llf_chain_fetcher_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err),
    .seg_enable (seg_enable),
    .seg_done   (seg_done),
    .chain_done (chain_done),
    .chain_err  (chain_err)
);

// File: tb/llf_chain_fetcher_bench.sv
// Bench: behavioural reference model compared every cycle, plus scenarios.
module llf_chain_fetcher_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAXB = 32'h1FFC;
    localparam logic [31:0] CFG_A = 32'hC0000001 | (32'h3 << 12) | (32'h3 << 16)
                                  | (32'hF << 20) | (32'hF << 24);
    localparam logic [31:0] CFG_B = 32'h40000001 | (32'h2 << 2) | (32'h5 << 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        busy, rd_req, seg_enable, chain_done, chain_err;
    logic [31:0] rd_addr, seg_link, seg_count, seg_src, seg_dst, seg_cfg;
    logic        rd_valid = 1'b0;
    logic        rd_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        seg_done = 1'b0;

    llf_chain_fetcher u_llf_chain_fetcher (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_err(rd_err), .seg_link(seg_link),
        .seg_count(seg_count), .seg_src(seg_src), .seg_dst(seg_dst),
        .seg_cfg(seg_cfg), .seg_enable(seg_enable), .seg_done(seg_done),
        .chain_done(chain_done), .chain_err(chain_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit fin = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory and stimulus state
    logic [31:0] mem [0:255];
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    logic        mover_on = 1'b1;
    logic        force_done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          mv_cnt = 0;
    int          seg_starts = 0;
    int          done_seen = 0;
    int          err_seen = 0;
    logic        en_prev = 1'b0;

    // Reference model
    int          m_phase = 0;
    int          m_q[$];
    int          m_off;
    logic [31:0] m_base = '0;
    logic [31:0] m_w [0:7];
    logic        m_done = 1'b0;
    logic        m_err = 1'b0;

    always @(posedge clk) begin
        m_done = 1'b0;
        m_err  = 1'b0;
        if (!rst_n) begin
            m_phase = 0;
            m_q.delete();
            m_base = '0;
            for (int i = 0; i < 8; i++) m_w[i] = '0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_base = start_addr & ~32'h1F;
                    m_q = '{0, 4, 5, 6, 7};
                    m_w[7][0] = 1'b0;
                    m_phase = 1;
                end
                1: if (rd_valid) begin
                    if (rd_err) begin
                        m_err = 1'b1;
                        m_phase = 0;
                    end else begin
                        m_off = m_q.pop_front();
                        m_w[m_off] = rd_data;
                        if (m_off == 4 && rd_data > MAXB) begin
                            m_err = 1'b1;
                            m_phase = 0;
                        end else if (m_off == 7) begin
                            m_phase = 2;
                        end
                    end
                end
                default: if (seg_done && m_w[7][0]) begin
                    m_w[7][0] = 1'b0;
                    if (m_w[0][1] && (m_w[0] & ~32'h1F) != 0) begin
                        m_base = m_w[0] & ~32'h1F;
                        m_q = '{0, 4, 5, 6, 7};
                        m_phase = 1;
                    end else begin
                        m_done = 1'b1;
                        m_phase = 0;
                    end
                end
            endcase
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(busy === (m_phase != 0), "R2 busy", 32'(busy), 32'(m_phase != 0));
            chk(rd_req === (m_phase == 1), "R3 rd_req", 32'(rd_req), 32'(m_phase == 1));
            if (m_phase == 1)
                chk(rd_addr === m_base + 32'(m_q[0] * 4), "R3 rd_addr", rd_addr,
                    m_base + 32'(m_q[0] * 4));
            chk(seg_link === m_w[0], "R4 seg_link", seg_link, m_w[0]);
            chk(seg_count === m_w[4], "R4 seg_count", seg_count, m_w[4]);
            chk(seg_src === m_w[5], "R4 seg_src", seg_src, m_w[5]);
            chk(seg_dst === m_w[6], "R4 seg_dst", seg_dst, m_w[6]);
            chk(seg_cfg === m_w[7], "R10 seg_cfg", seg_cfg, m_w[7]);
            chk(seg_enable === m_w[7][0], "R10 seg_enable", 32'(seg_enable), 32'(m_w[7][0]));
            chk(chain_done === m_done, "R7 chain_done", 32'(chain_done), 32'(m_done));
            chk(chain_err === m_err, "R8 chain_err", 32'(chain_err), 32'(m_err));
        end
    end

    // Memory responder with random stalls
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_valid = rd_req && (lfsr[1:0] != 2'b00);
        rd_data  = rd_req ? mem[rd_addr[9:2]] : '0;
        rd_err   = rd_req && err_on && (rd_addr == err_addr);
    end

    // Data mover model and event counters
    always @(negedge clk) begin
        if (force_done) begin
            seg_done = 1'b1;
        end else if (seg_enable && mover_on) begin
            mv_cnt++;
            seg_done = (mv_cnt == 3);
            if (seg_done) mv_cnt = 0;
        end else begin
            seg_done = 1'b0;
            mv_cnt = 0;
        end
        if (rst_n) begin
            if (seg_enable && !en_prev) seg_starts++;
            if (chain_done) done_seen++;
            if (chain_err) err_seen++;
        end
        en_prev = seg_enable;
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !fin) begin
            fin = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic put_desc(input int a, input logic [31:0] link, input logic [31:0] cnt,
                            input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] cfg);
        mem[a/4]     = link;
        mem[a/4 + 1] = 32'hBAD0_0001;
        mem[a/4 + 2] = 32'hBAD0_0002;
        mem[a/4 + 3] = 32'hBAD0_0003;
        mem[a/4 + 4] = cnt;
        mem[a/4 + 5] = src;
        mem[a/4 + 6] = dst;
        mem[a/4 + 7] = cfg;
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        start_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    int s0, d0, e0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && rd_req === 1'b0, "R1 reset idle", {busy, rd_req}, 0);
        chk(seg_enable === 1'b0 && seg_cfg === 0, "R1 reset enable", seg_cfg, 0);
        chk(chain_done === 1'b0 && chain_err === 1'b0, "R1 reset pulses",
            {chain_done, chain_err}, 0);
        rst_n = 1'b1;

        // Three-descriptor chain, unaligned start, busy start ignored, count at limit
        put_desc('h040, 32'h0A2, 32'h100, 32'h1000, 32'h2000, CFG_A);
        put_desc('h0A0, 32'h102, MAXB, 32'h3000, 32'h4000, CFG_B);
        put_desc('h100, 32'h000, 32'h8, 32'h5000, 32'h6000, CFG_A);
        s0 = seg_starts; d0 = done_seen; e0 = err_seen;
        kick(32'h04B);
        repeat (4) @(negedge clk);
        kick(32'h200);
        wait_idle();
        chk(seg_starts - s0 == 3, "R6 followed links", 32'(seg_starts - s0), 3);
        chk(done_seen - d0 == 1, "R7 one done pulse", 32'(done_seen - d0), 1);
        chk(err_seen - e0 == 0, "R9 count at limit accepted", 32'(err_seen - e0), 0);
        chk(seg_count === MAXB || seg_count === 32'h8, "R2 busy start ignored", seg_count, 8);

        // Chain flag set but address zero: ends after one segment
        put_desc('h140, 32'h002, 32'h40, 32'h7000, 32'h7100, CFG_A);
        s0 = seg_starts; d0 = done_seen;
        kick(32'h140);
        wait_idle();
        chk(seg_starts - s0 == 1, "R7 zero address ends", 32'(seg_starts - s0), 1);
        chk(done_seen - d0 == 1, "R7 done after zero link", 32'(done_seen - d0), 1);

        // Address present but chain flag clear: not followed
        put_desc('h180, 32'h1C0, 32'h20, 32'h7200, 32'h7300, CFG_B);
        put_desc('h1C0, 32'h000, 32'h20, 32'h7400, 32'h7500, CFG_B);
        s0 = seg_starts;
        kick(32'h180);
        wait_idle();
        chk(seg_starts - s0 == 1, "R6 flag clear not followed", 32'(seg_starts - s0), 1);

        // Read error on the second descriptor's source word
        put_desc('h200, 32'h242, 32'h10, 32'h7600, 32'h7700, CFG_A);
        put_desc('h240, 32'h000, 32'h10, 32'h7800, 32'h7900, CFG_A);
        err_on = 1'b1; err_addr = 32'h254;
        s0 = seg_starts; d0 = done_seen; e0 = err_seen;
        kick(32'h200);
        wait_idle();
        err_on = 1'b0;
        chk(err_seen - e0 == 1, "R8 error pulse", 32'(err_seen - e0), 1);
        chk(done_seen - d0 == 0, "R8 no done after error", 32'(done_seen - d0), 0);
        chk(seg_starts - s0 == 1, "R8 no segment after error", 32'(seg_starts - s0), 1);

        // Count above limit
        put_desc('h280, 32'h000, MAXB + 1, 32'h7A00, 32'h7B00, CFG_A);
        s0 = seg_starts; e0 = err_seen;
        kick(32'h280);
        wait_idle();
        chk(err_seen - e0 == 1, "R9 oversize count aborts", 32'(err_seen - e0), 1);
        chk(seg_starts - s0 == 0, "R9 no segment started", 32'(seg_starts - s0), 0);

        // Disabled descriptor: seg_done ignored, then reset clears everything
        put_desc('h2C0, 32'h000, 32'h55, 32'h7C00, 32'h7D00, CFG_A & ~32'h1);
        d0 = done_seen;
        kick(32'h2C0);
        repeat (20) @(negedge clk);
        chk(busy === 1'b1 && seg_enable === 1'b0, "R5 paused channel", {busy, seg_enable}, 2);
        chk(seg_count === 32'h55, "R4 count loaded", seg_count, 32'h55);
        @(posedge clk); force_done = 1'b1;
        @(posedge clk); force_done = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy === 1'b1 && done_seen == d0, "R5 seg_done ignored", 32'(busy), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && rd_req === 1'b0 && seg_count === 0, "R1 reset mid-chain",
            seg_count, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        fin = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule